// File: doc/BRIEF.md
# Temperature Alert Controller

This block watches a stream of digital temperature samples and decides when an active-low alert line should be pulled down. Software programs three signed limits: a window top, a window bottom and a critical trip point. It also programs a hysteresis amount, an operating mode and two enable bits through a small register port, and it can issue a clear command. Each sample arrives on a plain bus with a one-cycle valid strobe. The alert line is open-drain in style: the block either pulls it low or releases it (`alert_n` high).

Each limit has a tracker that raises a flag when the temperature goes past the limit. The flag drops only once the temperature has come back past the limit by the hysteresis amount. Three modes decide how the flags reach the alert line:

- **Interrupt mode:** latches a window crossing until software clears it.
- **Compare mode:** mirrors the window flags directly.
- **Critical-only mode:** looks at the critical flag alone.

In every mode the critical flag behaves as a comparator that no software clear can release.

Temperatures and limits are 13-bit two's-complement values in units of 1/16 degree.

Top module: `therm_alert_top`

## Requirements
- R1: After reset `alert_n` is 1 and every register reads 0.
- R2: Register map. Address 0 is control: bit0 enable, bit1 window enable, bits3:2 mode (00 interrupt, 01 compare, 1x critical-only), bits5:4 hysteresis select. Address 1 is the window top, address 2 the window bottom and address 3 the critical limit; each stores wdata[12:0] and reads back sign-extended to 16 bits. Writing address 4 with bit0 = 1 is the clear command, and address 4 reads 0.
- R3: In interrupt and compare modes with the window enabled, a sample above the top or below the bottom drives `alert_n` low. With the window disabled, window crossings never drive it.
- R4: In interrupt mode a window crossing stays latched, even after the temperature returns inside, until a clear command releases it.
- R5: In interrupt mode, after a clear, samples that stay outside the window do not reassert the alert. Only a fresh crossing, made after the flag has dropped, reasserts it.
- R6: In compare mode the clear command has no effect. The alert releases only when the temperature is back inside the window by the hysteresis.
- R7: In critical-only mode, window crossings are ignored and only a sample above the critical limit drives `alert_n` low.
- R8: In every mode, a sample above the critical limit drives `alert_n` low. A clear does not release it; it releases only when a sample is at or below the critical limit minus the hysteresis.
- R9: Hysteresis select 0/1/2/3 gives 0/24/48/96 sixteenths. A high-side flag (window top, critical limit) drops when temp <= limit - H. The window-bottom flag drops when temp >= bottom + H.
- R10: With enable at 0, `alert_n` is 1 and all flags and latches are reset. After re-enabling, the alert stays released until a new sample crosses a limit.
- R11: Comparisons are signed, so negative temperatures and limits order correctly.
- R12: A sample taken at a clock edge is reflected on `alert_n` right after that edge. Without a valid strobe, and after limit writes, the output keeps its value until the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| temp_val | input | 13 | Temperature sample, signed 1/16 degree |
| temp_vld | input | 1 | Sample valid strobe |
| alert_n | output | 1 | Alert, 0 = pulled low, 1 = released |

## Verification
The bench builds the block with its default widths: 13-bit samples, a 3-bit address and 16-bit register data. These widths make the sign extension on readback observable and put negative limits such as -5 degrees within reach. The scenarios cover:

- hysteresis offsets of 24, 48 and 96 sixteenths at the exact sample where each flag drops;
- mode changes while flags are still set;
- disabling the block and enabling it again.

All expected values are derived from the limit arithmetic stated in the requirements.

// File: rtl/therm_alert_pkg.sv
`timescale 1ns/1ps
package therm_alert_pkg;
  typedef enum logic [1:0] {
    MODE_LATCH = 2'b00,
    MODE_FOLLOW = 2'b01,
    MODE_CRIT = 2'b10,
    MODE_CRIT2 = 2'b11
  } alert_mode_e;

  localparam int HYST_W = 8;

  function automatic logic [HYST_W-1:0] hyst_amount(input logic [1:0] sel);
    case (sel)
      2'd0: hyst_amount = 8'd0;
      2'd1: hyst_amount = 8'd24;
      2'd2: hyst_amount = 8'd48;
      default: hyst_amount = 8'd96;
    endcase
  endfunction

  function automatic logic is_crit_only(input logic [1:0] m);
    is_crit_only = m[1];
  endfunction
endpackage

// File: rtl/therm_alert_regs.sv
`timescale 1ns/1ps
module therm_alert_regs #(
  parameter int TW = 13,
  parameter int AW = 3,
  parameter int DW = 16,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] ctl,
  output logic [TW-1:0] lim [3],
  output logic          clr
);
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_LIM0 = AW'(1);
  localparam logic [AW-1:0] A_CLR = AW'(4);

  function automatic logic [DW-1:0] sext(input logic [TW-1:0] v);
    sext = {{(DW-TW){v[TW-1]}}, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else if (we && addr == A_CTL) ctl <= wdata[CW-1:0];
  end

  for (genvar i = 0; i < 3; i++) begin : g_lim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lim[i] <= '0;
      else if (we && addr == A_LIM0 + AW'(i)) lim[i] <= wdata[TW-1:0];
    end
  end

  assign clr = we && (addr == A_CLR) && wdata[0];

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTL: rdata = {{(DW-CW){1'b0}}, ctl};
      A_LIM0: rdata = sext(lim[0]);
      A_LIM0 + AW'(1): rdata = sext(lim[1]);
      A_LIM0 + AW'(2): rdata = sext(lim[2]);
      default: rdata = '0;
    endcase
  end

  AST_CLR_ONLY_ADDR4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (we && addr == A_CLR)) else $error("clear without write"); // R2
endmodule

// File: rtl/therm_limit_track.sv
`timescale 1ns/1ps
module therm_limit_track #(
  parameter int TW = 13,
  parameter int HW = 8,
  parameter bit HI_SIDE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          upd,
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] lim,
  input  logic [HW-1:0] hyst,
  output logic          flag,
  output logic          set_now
);
  localparam int EW = TW + 2;

  function automatic logic signed [EW-1:0] ext(input logic [TW-1:0] v);
    ext = $signed({{2{v[TW-1]}}, v});
  endfunction

  function automatic logic past_limit(input logic [TW-1:0] t, input logic [TW-1:0] l);
    past_limit = HI_SIDE ? (ext(t) > ext(l)) : (ext(t) < ext(l));
  endfunction

  function automatic logic back_inside(input logic [TW-1:0] t, input logic [TW-1:0] l,
                                       input logic [HW-1:0] h);
    logic signed [EW-1:0] hs;
    hs = $signed({{(EW-HW){1'b0}}, h});
    back_inside = HI_SIDE ? (ext(t) <= ext(l) - hs) : (ext(t) >= ext(l) + hs);
  endfunction

  logic beyond, recovered;
  assign beyond = past_limit(temp, lim);
  assign recovered = back_inside(temp, lim, hyst);
  assign set_now = en && upd && !flag && beyond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (!en) flag <= 1'b0;
    else if (upd) begin
      if (!flag && beyond) flag <= 1'b1;
      else if (flag && recovered) flag <= 1'b0;
    end
  end

  AST_SET_ON_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd && beyond) |=> flag) else $error("flag not set"); // R3
  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd && flag && !recovered) |=> flag) else $error("flag dropped early"); // R9
  AST_NO_SAMPLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd) |=> ($stable(flag) || !flag)) else $error("flag rose without sample"); // R12
endmodule

// File: rtl/therm_alert_core.sv
`timescale 1ns/1ps
module therm_alert_core
  import therm_alert_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       win_en,
  input  logic [1:0] mode,
  input  logic       clr,
  input  logic       hi_flag,
  input  logic       lo_flag,
  input  logic       crit_flag,
  input  logic       hi_set,
  input  logic       lo_set,
  output logic       alert_n,
  output logic       latch_q
);
  logic win_hit, win_set, crit_only, evt;

  assign win_hit = win_en && (hi_flag || lo_flag);
  assign win_set = win_en && (hi_set || lo_set) && (mode == MODE_LATCH);
  assign crit_only = is_crit_only(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b0;
    else if (!en) latch_q <= 1'b0;
    else if (win_set) latch_q <= 1'b1;
    else if (clr) latch_q <= 1'b0;
  end

  always_comb begin
    if (!en) evt = 1'b0;
    else if (crit_only) evt = crit_flag;
    else if (mode == MODE_FOLLOW) evt = crit_flag || win_hit;
    else evt = crit_flag || latch_q;
  end

  assign alert_n = !evt;

  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> alert_n) else $error("alert while disabled"); // R10
  AST_CRIT_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_only && !crit_flag) |-> alert_n) else $error("window alert in crit mode"); // R7
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !clr) |=> (latch_q || !en)) else $error("latch lost"); // R4
endmodule

// File: rtl/therm_alert_top.sv
`timescale 1ns/1ps
module therm_alert_top
  import therm_alert_pkg::*;
#(
  parameter int TW = 13,
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_we,
  output logic [DW-1:0] reg_rdata,
  input  logic [TW-1:0] temp_val,
  input  logic          temp_vld,
  output logic          alert_n
);
  localparam int CW = 6;

  logic [CW-1:0]     ctl;
  logic [TW-1:0]     lim [3];
  logic              clr;
  logic              en, win_en;
  logic [1:0]        mode;
  logic [HYST_W-1:0] hyst;
  logic [2:0]        flag, set_now;
  logic              latch_q;

  therm_alert_regs #(.TW(TW), .AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .rdata(reg_rdata), .ctl(ctl), .lim(lim), .clr(clr)
  );

  assign en = ctl[0];
  assign win_en = ctl[1];
  assign mode = ctl[3:2];
  assign hyst = hyst_amount(ctl[5:4]);

  // index 0: window top, 1: window bottom, 2: critical
  for (genvar i = 0; i < 3; i++) begin : g_trk
    therm_limit_track #(.TW(TW), .HW(HYST_W), .HI_SIDE(i != 1)) u_trk (
      .clk(clk), .rst_n(rst_n), .en(en), .upd(temp_vld), .temp(temp_val),
      .lim(lim[i]), .hyst(hyst), .flag(flag[i]), .set_now(set_now[i])
    );
  end

  therm_alert_core u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .win_en(win_en), .mode(mode), .clr(clr),
    .hi_flag(flag[0]), .lo_flag(flag[1]), .crit_flag(flag[2]),
    .hi_set(set_now[0]), .lo_set(set_now[1]), .alert_n(alert_n), .latch_q(latch_q)
  );

  AST_CRIT_IGNORES_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && en && flag[2] && !temp_vld) |=> !alert_n) else $error("crit cleared"); // R8
  AST_FOLLOW_IGNORES_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && en && mode == MODE_FOLLOW && !alert_n && !temp_vld) |=> !alert_n)
    else $error("compare cleared"); // R6
endmodule

// File: tb/therm_alert_top_tb_top.sv
`timescale 1ns/1ps
module therm_alert_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 13;
  localparam int AW = 3;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic          reg_we = 1'b0;
  logic [DW-1:0] reg_rdata;
  logic [TW-1:0] temp_val = '0;
  logic          temp_vld = 1'b0;
  logic          alert_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  therm_alert_top #(.TW(TW), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .temp_val(temp_val),
    .temp_vld(temp_vld), .alert_n(alert_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = DW'(d); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic sample(input int t);
    @(negedge clk);
    temp_val = TW'(t); temp_vld = 1'b1;
    @(negedge clk);
    temp_vld = 1'b0;
  endtask

  task automatic clear_cmd();
    wr(4, 1);
  endtask

  task automatic alert_is(input string tag, input int exp);
    chk(tag, int'(alert_n), exp);
  endtask

  // upper 1280 (80 C), lower -80 (-5 C), critical 1520 (95 C)
  task automatic t_reset_regs();
    alert_is("R1 alert after reset", 1);
    rd_chk("R1 ctl after reset", 0, 0);
    rd_chk("R1 upper after reset", 1, 0);
    wr(1, 1280); wr(2, 16'hFFB0); wr(3, 1520);
    rd_chk("R2 upper readback", 1, 1280);
    rd_chk("R11 R2 lower sign-extended", 2, 16'hFFB0);
    rd_chk("R2 crit readback", 3, 1520);
    wr(0, 16'h0007);
    rd_chk("R2 ctl readback", 0, 7);
    rd_chk("R2 clear addr reads 0", 4, 0);
  endtask

  task automatic t_compare();
    wr(0, 16'h0007);
    sample(1000); alert_is("R3 inside window", 1);
    sample(1281); alert_is("R3 above top", 0);
    clear_cmd(); alert_is("R6 clear ignored in compare", 0);
    sample(1280); alert_is("R6 back inside releases", 1);
    sample(-81); alert_is("R11 below negative bottom", 0);
    sample(-80); alert_is("R11 at bottom releases", 1);
  endtask

  task automatic t_hyst();
    wr(0, 16'h0027);
    sample(1300); alert_is("R9 h48 set", 0);
    sample(1260); alert_is("R9 h48 still held", 0);
    sample(1232); alert_is("R9 h48 drops at top-48", 1);
    wr(0, 16'h0037);
    sample(1300); alert_is("R9 h96 set", 0);
    sample(1185); alert_is("R9 h96 held at top-95", 0);
    sample(1184); alert_is("R9 h96 drops at top-96", 1);
    wr(0, 16'h0017);
    sample(-90); alert_is("R9 h24 bottom set", 0);
    sample(-57); alert_is("R9 h24 bottom held", 0);
    sample(-56); alert_is("R9 h24 bottom drops", 1);
  endtask

  task automatic t_interrupt();
    wr(0, 16'h0003);
    sample(1300); alert_is("R4 crossing latched", 0);
    sample(1000); alert_is("R4 stays after return", 0);
    clear_cmd(); alert_is("R4 clear releases", 1);
    sample(1300); alert_is("R5 fresh crossing", 0);
    clear_cmd(); alert_is("R4 clear again", 1);
    sample(1310); alert_is("R5 no retrigger outside", 1);
    sample(1000); alert_is("R5 back inside", 1);
    sample(1300); alert_is("R5 new crossing retriggers", 0);
    clear_cmd();
    sample(1000); alert_is("R4 idle after clear", 1);
  endtask

  task automatic t_window_off();
    wr(0, 16'h0005);
    sample(1400); alert_is("R3 window off high", 1);
    sample(-200); alert_is("R3 window off low", 1);
  endtask

  task automatic t_critical();
    wr(0, 16'h002B);
    sample(1400); alert_is("R7 window ignored high", 1);
    sample(-200); alert_is("R7 window ignored low", 1);
    sample(1521); alert_is("R7 crit asserts", 0);
    clear_cmd(); alert_is("R8 clear ignored crit", 0);
    sample(1500); alert_is("R8 crit held by hyst", 0);
    sample(1472); alert_is("R8 R9 crit releases", 1);
    sample(1000);
    wr(0, 16'h0003);
    sample(1000); alert_is("R8 interrupt idle", 1);
    sample(1600); alert_is("R8 crit in interrupt mode", 0);
    clear_cmd(); alert_is("R8 clear leaves crit", 0);
    sample(1000); alert_is("R8 crit comparator release", 1);
  endtask

  task automatic t_enable();
    wr(0, 16'h0003);
    sample(1300); alert_is("R10 latched before disable", 0);
    wr(0, 16'h0002); alert_is("R10 disabled releases", 1);
    sample(1400); alert_is("R10 disabled ignores sample", 1);
    wr(0, 16'h0003); alert_is("R10 re-enable state reset", 1);
    sample(1400); alert_is("R10 new sample crosses", 0);
    clear_cmd();
    sample(1000);
  endtask

  task automatic t_timing();
    wr(0, 16'h0007);
    sample(1000); alert_is("R12 baseline", 1);
    @(negedge clk); temp_val = TW'(1300); temp_vld = 1'b0;
    @(negedge clk); alert_is("R12 no strobe no change", 1);
    wr(1, 900); alert_is("R12 limit write waits for sample", 1);
    sample(1000); alert_is("R12 new limit on sample", 0);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_regs();
    t_compare();
    t_hyst();
    t_interrupt();
    t_window_off();
    t_critical();
    t_enable();
    t_timing();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule